// File: doc/BRIEF.md
# Multicast Buffer Loan Scoreboard

This block keeps the books for a pool of packet buffers set aside only for multicast traffic. A receive agent takes a free buffer from the pool through the allocate port. It then loans that buffer to several transmit destinations at once by presenting the buffer index together with a bitmap of the destinations that will read it. The scoreboard remembers that bitmap for each buffer.

Each destination hands the buffer back separately through the return port, naming the buffer and its own destination number. Every accepted return clears one bit. The return that clears the last bit sends the buffer to the back of the multicast free list, and the buffer can then be allocated again. Returns that name a destination not holding the buffer are rejected with an error pulse, and the scoreboard keeps its state. A loan whose bitmap is empty sends the buffer straight back to the pool.

Top module: `mcl_loan_scoreboard`

## Requirements
- R1: After a synchronous reset every one of the NUM_BUFS buffers is free. `free_count` equals NUM_BUFS, `alloc_empty` is 0 and `ret_err` is 0. The free list then holds the buffer indices in ascending order starting at 0.
- R2: While the free list is not empty, asserting `alloc_req` drives `alloc_valid` high in the same cycle, and `alloc_buf` carries the oldest entry of the list. At the clock edge that entry is removed and `free_count` drops by one.
- R3: When `free_count` is 0, `alloc_empty` is 1. An `alloc_req` then leaves `alloc_valid` at 0 and `alloc_buf` at 0, and changes no state.
- R4: A loan records `loan_mask` for `loan_buf`, where bit d of the mask stands for destination d. The buffer stays out of the free list until every set bit has been cleared by a return.
- R5: A return for a destination whose bit is set clears only that bit. If it was the last set bit, the buffer goes to the tail of the free list, and `free_count` is one higher in the cycle after the return.
- R6: A return for a destination whose bit is already clear is rejected. `ret_err` is 1 for the single cycle after it, and the buffer's bitmap does not change.
- R7: A loan with an all-zero `loan_mask` puts the buffer on the tail of the free list at that clock edge.
- R8: A completing return and a zero-mask loan in the same cycle both reach the free list at one edge. The returned buffer goes in ahead of the loaned one.
- R9: A return that names the buffer being loaned in the same cycle is rejected as in R6. The new loan bitmap is stored unchanged.
- R10: Returns name destinations 0 to NUM_DESTS-1 with a binary `ret_dest` field. With the default parameters there are 16 destinations, and a 4-bit id selects bit `ret_dest` of the stored mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loan_valid | input | 1 | Loan request strobe |
| loan_buf | input | BUF_W | Buffer being loaned |
| loan_mask | input | NUM_DESTS | Destinations that receive the loan |
| ret_valid | input | 1 | Return strobe |
| ret_buf | input | BUF_W | Buffer being returned |
| ret_dest | input | DEST_W | Destination returning the buffer |
| alloc_req | input | 1 | Request for a free multicast buffer |
| alloc_valid | output | 1 | A buffer is granted this cycle |
| alloc_buf | output | BUF_W | Granted buffer index, 0 when none |
| alloc_empty | output | 1 | Free list is empty |
| free_count | output | CNT_W | Number of buffers in the free list |
| ret_err | output | 1 | Previous cycle's return was rejected |

## Verification
Allocation is combinational. `alloc_valid` and `alloc_buf` are sampled in the same cycle as `alloc_req`, after the inputs have settled. Every other effect lands at the next clock edge: the change to `free_count` from an allocation, a loan or a completing return, and the `ret_err` pulse. Those values are therefore read one edge after each stimulus. Inputs change on the falling edge, and samples are taken one nanosecond after it or after the rising edge. Freeing order is checked by draining the whole list and comparing each granted index with the sequence expected from the requirements.

// File: rtl/mcl_pkg.sv
package mcl_pkg;

    localparam int unsigned MCL_BUFS  = 16;
    localparam int unsigned MCL_DESTS = 16;

    // Outcome of a return presented to the scoreboard
    typedef enum logic [1:0] {
        RET_NONE    = 2'd0,
        RET_PARTIAL = 2'd1,
        RET_LAST    = 2'd2,
        RET_REJECT  = 2'd3
    } ret_kind_e;

    // One push request toward the free list
    typedef struct packed {
        logic       valid;
        logic [7:0] idx;
    } push_req_t;

    // Circular pointer advance
    function automatic int unsigned wrap_add(int unsigned p, int unsigned k, int unsigned n);
        int unsigned s;
        s = p + k;
        if (s >= n) s = s - n;
        return s;
    endfunction

endpackage

// File: rtl/mcl_score.sv
module mcl_score
    import mcl_pkg::*;
#(
    parameter int unsigned NB = MCL_BUFS,
    parameter int unsigned ND = MCL_DESTS,
    localparam int unsigned BW = (NB > 1) ? $clog2(NB) : 1,
    localparam int unsigned DW = (ND > 1) ? $clog2(ND) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          loan_valid,
    input  logic [BW-1:0] loan_buf,
    input  logic [ND-1:0] loan_mask,
    input  logic          ret_valid,
    input  logic [BW-1:0] ret_buf,
    input  logic [DW-1:0] ret_dest,
    output ret_kind_e     ret_kind,
    output logic          loan_frees,
    output logic          ret_err
);

    logic [ND-1:0] mask_q [NB];
    logic [ND-1:0] cur_mask;
    logic [ND-1:0] dest_bit;
    logic          clash;

    always_comb begin
        cur_mask   = mask_q[ret_buf];
        dest_bit   = ND'(1) << ret_dest;
        clash      = loan_valid && (loan_buf == ret_buf);
        loan_frees = loan_valid && (loan_mask == '0);
        ret_kind   = RET_NONE;
        if (ret_valid) begin
            if (clash || ((cur_mask & dest_bit) == '0))
                ret_kind = RET_REJECT;
            else if ((cur_mask & ~dest_bit) == '0)
                ret_kind = RET_LAST;
            else
                ret_kind = RET_PARTIAL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(NB); i++) mask_q[i] <= '0;
            ret_err <= 1'b0;
        end else begin
            ret_err <= (ret_kind == RET_REJECT);
            if (ret_kind == RET_PARTIAL || ret_kind == RET_LAST)
                mask_q[ret_buf] <= cur_mask & ~dest_bit;
            if (loan_valid)
                mask_q[loan_buf] <= loan_mask;
        end
    end

    AST_LOAN_RECORD: assert property (@(posedge clk) disable iff (rst)
        loan_valid |=> mask_q[$past(loan_buf)] == $past(loan_mask)); // R4

    AST_STALE_RETURN: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && !loan_valid && !mask_q[ret_buf][ret_dest])
        |=> (ret_err && mask_q[$past(ret_buf)] == $past(mask_q[ret_buf]))); // R6

    AST_CLASH_REJECT: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && loan_valid && ret_buf == loan_buf) |=> ret_err); // R9

    AST_GOOD_RETURN: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && !loan_valid && mask_q[ret_buf][ret_dest])
        |=> (!ret_err && !mask_q[$past(ret_buf)][$past(ret_dest)])); // R5

endmodule

// File: rtl/mcl_freelist.sv
module mcl_freelist
    import mcl_pkg::*;
#(
    parameter int unsigned NB = MCL_BUFS,
    localparam int unsigned BW = (NB > 1) ? $clog2(NB) : 1,
    localparam int unsigned CW = $clog2(NB + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  push_req_t     push_a,
    input  push_req_t     push_b,
    input  logic          pop,
    output logic [BW-1:0] head_idx,
    output logic [CW-1:0] count,
    output logic          empty
);

    logic [BW-1:0] slot_q [NB];
    logic [BW-1:0] head_q;
    logic [BW-1:0] tail_q;
    logic [BW-1:0] tail_b;
    logic [CW-1:0] count_q;
    logic          do_pop;

    assign head_idx = slot_q[head_q];
    assign count    = count_q;
    assign empty    = (count_q == '0);
    assign do_pop   = pop && !empty;
    assign tail_b   = BW'(wrap_add(int'(tail_q), int'(push_a.valid), NB));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(NB); i++) slot_q[i] <= BW'(i);
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= CW'(NB);
        end else begin
            if (push_a.valid) slot_q[tail_q] <= push_a.idx[BW-1:0];
            if (push_b.valid) slot_q[tail_b] <= push_b.idx[BW-1:0];
            tail_q  <= BW'(wrap_add(int'(tail_q),
                           int'(push_a.valid) + int'(push_b.valid), NB));
            if (do_pop)
                head_q <= BW'(wrap_add(int'(head_q), 1, NB));
            count_q <= count_q + CW'(push_a.valid) + CW'(push_b.valid) - CW'(do_pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count_q <= CW'(NB)); // R5

    AST_POP_ONLY_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        (pop && empty) |=> count_q == $past(count_q) + CW'($past(push_a.valid))
                                      + CW'($past(push_b.valid))); // R3

    AST_DOUBLE_PUSH: assert property (@(posedge clk) disable iff (rst)
        (push_a.valid && push_b.valid)
        |=> (slot_q[$past(tail_q)] == $past(push_a.idx[BW-1:0]))); // R8

endmodule

// File: rtl/mcl_loan_scoreboard.sv
module mcl_loan_scoreboard
    import mcl_pkg::*;
#(
    parameter int unsigned NUM_BUFS  = MCL_BUFS,
    parameter int unsigned NUM_DESTS = MCL_DESTS,
    localparam int unsigned BUF_W  = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1,
    localparam int unsigned DEST_W = (NUM_DESTS > 1) ? $clog2(NUM_DESTS) : 1,
    localparam int unsigned CNT_W  = $clog2(NUM_BUFS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 loan_valid,
    input  logic [BUF_W-1:0]     loan_buf,
    input  logic [NUM_DESTS-1:0] loan_mask,
    input  logic                 ret_valid,
    input  logic [BUF_W-1:0]     ret_buf,
    input  logic [DEST_W-1:0]    ret_dest,
    input  logic                 alloc_req,
    output logic                 alloc_valid,
    output logic [BUF_W-1:0]     alloc_buf,
    output logic                 alloc_empty,
    output logic [CNT_W-1:0]     free_count,
    output logic                 ret_err
);

    ret_kind_e        ret_kind;
    logic             loan_frees;
    push_req_t        push_ret;
    push_req_t        push_loan;
    logic [BUF_W-1:0] head_idx;
    logic             list_empty;

    mcl_score #(.NB(NUM_BUFS), .ND(NUM_DESTS)) u_score (
        .clk        (clk),
        .rst        (rst),
        .loan_valid (loan_valid),
        .loan_buf   (loan_buf),
        .loan_mask  (loan_mask),
        .ret_valid  (ret_valid),
        .ret_buf    (ret_buf),
        .ret_dest   (ret_dest),
        .ret_kind   (ret_kind),
        .loan_frees (loan_frees),
        .ret_err    (ret_err)
    );

    // Completing return is pushed ahead of a zero-mask loan
    always_comb begin
        push_ret.valid  = (ret_kind == RET_LAST);
        push_ret.idx    = 8'(ret_buf);
        push_loan.valid = loan_frees;
        push_loan.idx   = 8'(loan_buf);
    end

    mcl_freelist #(.NB(NUM_BUFS)) u_free (
        .clk      (clk),
        .rst      (rst),
        .push_a   (push_ret),
        .push_b   (push_loan),
        .pop      (alloc_req),
        .head_idx (head_idx),
        .count    (free_count),
        .empty    (list_empty)
    );

    assign alloc_empty = list_empty;
    assign alloc_valid = alloc_req && !list_empty;
    assign alloc_buf   = alloc_valid ? head_idx : '0;

    AST_EMPTY_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        alloc_empty |-> (!alloc_valid && alloc_buf == '0)); // R3

    AST_GRANT_TAKES_ONE: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && !loan_valid && !ret_valid)
        |=> free_count == $past(free_count) - 1'b1); // R2

    AST_ZERO_LOAN_FREES: assert property (@(posedge clk) disable iff (rst)
        (loan_valid && loan_mask == '0 && !ret_valid && !alloc_req)
        |=> free_count == $past(free_count) + 1'b1); // R7

endmodule

// File: tb/mcl_loan_scoreboard_test.sv
module mcl_loan_scoreboard_test;

    localparam int NB = 16;
    localparam int ND = 16;

    typedef struct packed {
        logic        lv;
        logic [3:0]  lb;
        logic [15:0] lm;
        logic        rv;
        logic [3:0]  rb;
        logic [3:0]  rd;
        logic        ar;
        logic        ev;
        logic [3:0]  eb;
        logic [4:0]  ec;
        logic        ee;
    } vec_t;

    // loan, return, alloc stimulus with expected grant, count and error
    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 4'd0, 16'h0000, 1'b0, 4'd0, 4'd0,  1'b1, 1'b1, 4'd0, 5'd15, 1'b0}, // R2
        '{1'b0, 4'd0, 16'h0000, 1'b0, 4'd0, 4'd0,  1'b1, 1'b1, 4'd1, 5'd14, 1'b0}, // R2
        '{1'b1, 4'd0, 16'h0005, 1'b0, 4'd0, 4'd0,  1'b0, 1'b0, 4'd0, 5'd14, 1'b0}, // R4
        '{1'b1, 4'd1, 16'h0000, 1'b0, 4'd0, 4'd0,  1'b0, 1'b0, 4'd0, 5'd15, 1'b0}, // R7
        '{1'b0, 4'd0, 16'h0000, 1'b1, 4'd0, 4'd2,  1'b0, 1'b0, 4'd0, 5'd15, 1'b0}, // R5 partial
        '{1'b0, 4'd0, 16'h0000, 1'b1, 4'd0, 4'd2,  1'b0, 1'b0, 4'd0, 5'd15, 1'b1}, // R6
        '{1'b0, 4'd0, 16'h0000, 1'b1, 4'd0, 4'd0,  1'b1, 1'b1, 4'd2, 5'd15, 1'b0}  // R5 last
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        loan_valid = 1'b0;
    logic [3:0]  loan_buf = '0;
    logic [15:0] loan_mask = '0;
    logic        ret_valid = 1'b0;
    logic [3:0]  ret_buf = '0;
    logic [3:0]  ret_dest = '0;
    logic        alloc_req = 1'b0;
    logic        alloc_valid;
    logic [3:0]  alloc_buf;
    logic        alloc_empty;
    logic [4:0]  free_count;
    logic        ret_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mcl_loan_scoreboard #(.NUM_BUFS(NB), .NUM_DESTS(ND)) uut (
        .clk(clk), .rst(rst),
        .loan_valid(loan_valid), .loan_buf(loan_buf), .loan_mask(loan_mask),
        .ret_valid(ret_valid), .ret_buf(ret_buf), .ret_dest(ret_dest),
        .alloc_req(alloc_req), .alloc_valid(alloc_valid), .alloc_buf(alloc_buf),
        .alloc_empty(alloc_empty), .free_count(free_count), .ret_err(ret_err)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive on falling edge, check grant before rising edge, check state after it
    task automatic step(vec_t v, string req);
        @(negedge clk);
        loan_valid = v.lv; loan_buf = v.lb; loan_mask = v.lm;
        ret_valid = v.rv;  ret_buf = v.rb;  ret_dest = v.rd;
        alloc_req = v.ar;
        #1;
        if (v.ar) begin
            chk({req, " grant"}, int'(alloc_valid), int'(v.ev));
            chk({req, " index"}, int'(alloc_buf), int'(v.eb));
        end
        @(posedge clk);
        #1;
        loan_valid = 1'b0; ret_valid = 1'b0; alloc_req = 1'b0;
        chk({req, " count"}, int'(free_count), int'(v.ec));
        chk({req, " error"}, int'(ret_err), int'(v.ee));
    endtask

    function automatic vec_t mk(logic lv, int lb, int lm, logic rv, int rb, int rd,
                                logic ar, logic ev, int eb, int ec, logic ee);
        vec_t v;
        v.lv = lv; v.lb = 4'(lb); v.lm = 16'(lm);
        v.rv = rv; v.rb = 4'(rb); v.rd = 4'(rd);
        v.ar = ar; v.ev = ev; v.eb = 4'(eb); v.ec = 5'(ec); v.ee = ee;
        return v;
    endfunction

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        // R1 reset state
        chk("R1 count", int'(free_count), NB);
        chk("R1 empty", int'(alloc_empty), 0);
        chk("R1 err", int'(ret_err), 0);
        chk("R1 no grant", int'(alloc_valid), 0);

        for (int i = 0; i < NV; i++) step(VEC[i], "table");

        // R2 FIFO order: 3..15 then returned 1 and 0
        for (int i = 0; i < 15; i++) begin
            int e;
            e = (i < 13) ? i + 3 : ((i == 13) ? 1 : 0);
            step(mk(0, 0, 0, 0, 0, 0, 1, 1, e, 14 - i, 0), "R2 drain");
        end

        // R3 empty list
        @(negedge clk); #1;
        chk("R3 empty flag", int'(alloc_empty), 1);
        step(mk(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0), "R3 alloc on empty");

        // R8 and R10: loan to dest 15, then return plus zero-mask loan together
        step(mk(1, 7, 16'h8000, 0, 0, 0, 0, 0, 0, 0, 0), "R10 loan dest15");
        step(mk(1, 5, 0, 1, 7, 15, 0, 0, 0, 2, 0), "R8 dual push");
        step(mk(0, 0, 0, 0, 0, 0, 1, 1, 7, 1, 0), "R8 return first");
        step(mk(0, 0, 0, 0, 0, 0, 1, 1, 5, 0, 0), "R8 loan second");

        // R9 return colliding with a loan of the same buffer
        step(mk(1, 9, 16'h0003, 0, 0, 0, 0, 0, 0, 0, 0), "R4 loan two");
        step(mk(1, 9, 16'h0002, 1, 9, 1, 0, 0, 0, 0, 1), "R9 clash");
        step(mk(0, 0, 0, 1, 9, 0, 0, 0, 0, 0, 1), "R9 new mask kept");
        step(mk(0, 0, 0, 1, 9, 1, 0, 0, 0, 1, 0), "R4 last return");
        step(mk(0, 0, 0, 0, 0, 0, 1, 1, 9, 0, 0), "R5 reuse");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule